// File: doc/BRIEF.md
# Latched Status Register Bank with Interrupt Merge

The block keeps three 8-bit status registers whose bits are driven by condition inputs from surrounding logic. Each bit is configured by parameter as either an alarm (a level that may stay high for many cycles) or an event (a single-cycle pulse). A condition sets a hidden latched bit. The host never sees that latch directly. It sees a per-register snapshot, and a host write refreshes the snapshot only in the bit positions written with 1. The same write clears every latched bit that is 1 both in the current snapshot and in the written data. The host clears bits with a three-step sequence: write a mask, read the register, then write back the value read ANDed with the mask. This lets the host poll chosen bits without disturbing the others. An event that lands in the same cycle as a clear keeps its bit set.

Two of the registers can raise an interrupt, and each has its own interrupt enable register. An enabled alarm bit raises a pending interrupt on every change of its level, in both directions. An enabled event bit raises one when the event occurs. A pending source is released when the host clears the bit through the write-back, even if the alarm is still present. The active-low interrupt output is high only when no enabled source is pending. The third register holds information bits only and never drives the interrupt.

The host port is a plain synchronous register interface with no back-pressure. A write is taken on the clock edge where `bus_wr` is high. A read takes effect on the edge where `bus_rd` is high, and `bus_rdata` carries the result from that edge until the next read. The host is never stalled, so every access completes in one cycle.

Top module: `sreg_irq_bank`

## Requirements
- R1: After reset, every snapshot, latched bit, pending flag and enable register is 0, all sources are masked, `irq_n` is 1, and reads of addresses 0 to 4 return 0.
- R2: An event pulse or an active alarm on a condition input sets its latched bit on that clock edge. A later write with 1 in that position makes the bit readable as 1.
- R3: Bit positions written with 0 keep their snapshot value unchanged. With no write to a status register, its snapshot does not change.
- R4: A write clears each latched bit that is 1 in the snapshot and 1 in the written data. The snapshot positions that were written with 1 then show the post-clear state, and a cleared event bit stays 0 until a new event.
- R5: An alarm bit that is cleared while its alarm is still active reads 1 again. Once the alarm is gone, the next clear leaves it at 0.
- R6: An event that arrives in the same cycle as a write that clears its bit wins, so the bit stays set.
- R7: A bit whose enable is 0 never pulls `irq_n` low.
- R8: An enabled alarm bit pulls `irq_n` low in the cycle after its condition rises and again in the cycle after it falls.
- R9: An enabled event bit pulls `irq_n` low in the cycle after the pulse, in either interrupt-capable register.
- R10: A pending source is released when the host write clears its bit, even while the alarm is still present. `irq_n` returns to 1 only when no enabled source is pending. A write that only refreshes the snapshot does not release the source.
- R11: The information register (address 2) latches and reads like the others but never affects `irq_n`.
- R12: The address map is 0 for status A, 1 for status B, 2 for information, 3 for the enable of A and 4 for the enable of B. An enable bit of 1 lets that bit interrupt. Enable registers read back their value. `bus_rdata` shows the addressed value from the clock edge where `bus_rd` is high, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data / refresh-and-clear mask |
| bus_rdata | output | 8 | Read data, updated on a read edge |
| cond_a | input | 8 | Conditions for status register A |
| cond_b | input | 8 | Conditions for status register B |
| cond_info | input | 8 | Conditions for the information register |
| irq_n | output | 1 | Combined active-low interrupt |

## Verification
The hardest situation to reach is an event pulse that coincides with the clearing write-back of its own bit. The pulse must land on exactly the edge that takes the write. The bench has a task that raises the condition and the write strobe together, then releases both one cycle later. A second hard case is an alarm that stays high across a clear. The bench holds the alarm level while it runs the whole refresh, read and write-back sequence, and checks the interrupt at every step. It then drops the alarm and checks that the falling edge raises a second interrupt.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int NUM_REGS = 5;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  typedef enum logic [ADDR_W-1:0] {
    A_STAT_A = 3'd0,
    A_STAT_B = 3'd1,
    A_STAT_I = 3'd2,
    A_MASK_A = 3'd3,
    A_MASK_B = 3'd4
  } sreg_addr_e;
endpackage

// File: rtl/sreg_bank.sv
module sreg_bank #(
  parameter int DW = 8,
  parameter logic [DW-1:0] ALARM_BITS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cond,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] irq_en,
  output logic [DW-1:0] snap,
  output logic [DW-1:0] lat,
  output logic [DW-1:0] pend
);
  logic [DW-1:0] lat_q, snap_q, pend_q;
  logic [DW-1:0] lat_d, snap_d, pend_d;
  logic [DW-1:0] clr, chg;

  // Per-bit source kind: alarms interrupt on any level change, events on the pulse.
  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (ALARM_BITS[b]) begin : g_alarm
      logic prev;
      always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cond[b];
      end
      assign chg[b] = cond[b] ^ prev;
    end else begin : g_event
      assign chg[b] = cond[b];
    end
  end

  always_comb begin
    clr    = wr_stat ? (snap_q & wdata) : '0;
    lat_d  = cond | (lat_q & ~clr);
    pend_d = (chg & irq_en) | (pend_q & ~clr);
    snap_d = snap_q;
    for (int i = 0; i < DW; i++) begin
      if (wr_stat && wdata[i]) snap_d[i] = lat_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      snap_q <= '0;
      pend_q <= '0;
    end else begin
      lat_q  <= lat_d;
      snap_q <= snap_d;
      pend_q <= pend_d;
    end
  end

  assign snap = snap_q;
  assign lat  = lat_q;
  assign pend = pend_q & irq_en;
endmodule

// File: rtl/sreg_host_port.sv
module sreg_host_port
  import sreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     snap_a,
  input  logic [DW-1:0]     snap_b,
  input  logic [DW-1:0]     snap_i,
  output logic              wr_stat_a,
  output logic              wr_stat_b,
  output logic              wr_stat_i,
  output logic [DW-1:0]     en_a,
  output logic [DW-1:0]     en_b,
  output logic [DW-1:0]     bus_rdata
);
  logic [DW-1:0] rd_mux;

  assign wr_stat_a = bus_wr && (bus_addr == A_STAT_A);
  assign wr_stat_b = bus_wr && (bus_addr == A_STAT_B);
  assign wr_stat_i = bus_wr && (bus_addr == A_STAT_I);

  always_comb begin
    case (bus_addr)
      A_STAT_A: rd_mux = snap_a;
      A_STAT_B: rd_mux = snap_b;
      A_STAT_I: rd_mux = snap_i;
      A_MASK_A: rd_mux = en_a;
      A_MASK_B: rd_mux = en_b;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_a      <= '0;
      en_b      <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MASK_A) en_a <= bus_wdata;
      if (bus_wr && bus_addr == A_MASK_B) en_b <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sreg_irq_merge.sv
module sreg_irq_merge #(
  parameter int DW   = 8,
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0][DW-1:0] pend,
  output logic                    irq_n
);
  logic [NSRC-1:0] any_src;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign any_src[s] = |pend[s];
  end

  assign irq_n = ~(|any_src);
endmodule

// File: rtl/sreg_irq_bank.sv
module sreg_irq_bank
  import sreg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] ALARM_A = 8'h0F,
  parameter logic [DW-1:0] ALARM_B = 8'h81,
  parameter logic [DW-1:0] ALARM_I = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     cond_a,
  input  logic [DW-1:0]     cond_b,
  input  logic [DW-1:0]     cond_info,
  output logic              irq_n
);
  localparam int NSRC = 3;

  logic          wr_stat_a, wr_stat_b, wr_stat_i;
  logic [DW-1:0] en_a, en_b;
  logic [DW-1:0] snap_a, snap_b, snap_i;
  logic [DW-1:0] lat_a, lat_b, lat_i;
  logic [DW-1:0] pend_a, pend_b, pend_i;
  logic [NSRC-1:0][DW-1:0] pend_all;

  sreg_host_port #(.DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .snap_a(snap_a),
    .snap_b(snap_b), .snap_i(snap_i), .wr_stat_a(wr_stat_a),
    .wr_stat_b(wr_stat_b), .wr_stat_i(wr_stat_i), .en_a(en_a),
    .en_b(en_b), .bus_rdata(bus_rdata)
  );

  sreg_bank #(.DW(DW), .ALARM_BITS(ALARM_A)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .cond(cond_a), .wr_stat(wr_stat_a),
    .wdata(bus_wdata), .irq_en(en_a), .snap(snap_a), .lat(lat_a),
    .pend(pend_a)
  );

  sreg_bank #(.DW(DW), .ALARM_BITS(ALARM_B)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .cond(cond_b), .wr_stat(wr_stat_b),
    .wdata(bus_wdata), .irq_en(en_b), .snap(snap_b), .lat(lat_b),
    .pend(pend_b)
  );

  // Information register: enables tied off, so it can never interrupt.
  sreg_bank #(.DW(DW), .ALARM_BITS(ALARM_I)) u_bank_i (
    .clk(clk), .rst_n(rst_n), .cond(cond_info), .wr_stat(wr_stat_i),
    .wdata(bus_wdata), .irq_en('0), .snap(snap_i), .lat(lat_i),
    .pend(pend_i)
  );

  assign pend_all = {pend_i, pend_b, pend_a};

  sreg_irq_merge #(.DW(DW), .NSRC(NSRC)) u_merge (
    .pend(pend_all), .irq_n(irq_n)
  );
endmodule

// File: rtl/sreg_irq_bank_chk.sv
module sreg_irq_bank_chk
  import sreg_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] ALM_A = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [DW-1:0]     cond_a,
  input logic [DW-1:0]     snap_a,
  input logic [DW-1:0]     lat_a,
  input logic [DW-1:0]     en_a,
  input logic [DW-1:0]     en_b,
  input logic              irq_n
);
  // R2: a pulse on an event input is latched on that edge
  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cond_a & ~ALM_A)) |=> ((lat_a & $past(cond_a & ~ALM_A)) == $past(cond_a & ~ALM_A)));

  // R3: no status write means a stable snapshot
  p_snap_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_STAT_A) |=> $stable(snap_a));

  // R3: positions written with 0 hold their snapshot
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT_A) |=> (((snap_a ^ $past(snap_a)) & ~$past(bus_wdata)) == '0));

  // R5: an active alarm keeps its latched bit set, clear or not
  p_alarm_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cond_a & ALM_A)) |=> ((lat_a & $past(cond_a & ALM_A)) == $past(cond_a & ALM_A)));

  // R7: with every source masked the interrupt stays released
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a == '0 && en_b == '0) |-> irq_n);

  // R9: an enabled event pulls the interrupt low on the next cycle
  p_event_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(cond_a & en_a & ~ALM_A)) && !(bus_wr && bus_addr == A_MASK_A)) |=> !irq_n);

  // R12: enable register A reads back with one edge of latency
  p_en_readback_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_MASK_A) |=> (bus_rdata == $past(en_a)));
endmodule

bind sreg_irq_bank sreg_irq_bank_chk #(.DW(DW), .ALM_A(ALARM_A)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cond_a(cond_a), .snap_a(snap_a), .lat_a(lat_a), .en_a(en_a),
  .en_b(en_b), .irq_n(irq_n)
);

// File: tb/sim_sreg_irq_bank.sv
module sim_sreg_irq_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] cond_a = '0, cond_b = '0, cond_info = '0;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         rd_due = 1'b0;

  always #4 clk = ~clk;

  sreg_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cond_a(cond_a), .cond_b(cond_b), .cond_info(cond_info), .irq_n(irq_n)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: pops the expected read data one edge after each read strobe.
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (rd_due) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
    rd_due = bus_rd;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  // All driver tasks begin and end just after a rising edge.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic wr_with_event_a(input logic [7:0] d, input logic [7:0] ev);
    bus_addr = 3'd0; bus_wdata = d; bus_wr = 1'b1;
    cond_a = cond_a | ev;
    tick(1);
    bus_wr = 1'b0;
    cond_a = cond_a & ~ev;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    tick(1);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_a(input logic [7:0] ev);
    cond_a = cond_a | ev; tick(1); cond_a = cond_a & ~ev;
  endtask

  task automatic pulse_b(input logic [7:0] ev);
    cond_b = cond_b | ev; tick(1); cond_b = cond_b & ~ev;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state
    chk({7'd0, irq_n}, 8'h01, "R1 irq_n after reset");
    rd(3'd0, 8'h00, "R1 status A reset");
    rd(3'd1, 8'h00, "R1 status B reset");
    rd(3'd2, 8'h00, "R1 info reset");
    rd(3'd3, 8'h00, "R1 enable A reset");
    rd(3'd4, 8'h00, "R1 enable B reset");

    // R2: event latched, visible after refresh; masked so no interrupt (R7)
    pulse_a(8'h10);
    chk({7'd0, irq_n}, 8'h01, "R7 masked event keeps irq_n high");
    wr(3'd0, 8'h10);
    rd(3'd0, 8'h10, "R2 event bit4 visible");

    // R3: zero bits hold the snapshot
    pulse_a(8'h20);
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h10, "R3 bit5 not refreshed by 0");
    wr(3'd0, 8'h20);
    rd(3'd0, 8'h30, "R3 bit5 refreshed, bit4 held");

    // R4: write-back clears
    wr(3'd0, 8'h10);
    rd(3'd0, 8'h20, "R4 bit4 cleared");
    wr(3'd0, 8'h20);
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h00, "R4 all event bits clear");

    // R5: alarm bit survives a clear while present
    cond_a[0] = 1'b1;
    tick(1);
    wr(3'd0, 8'h01);
    rd(3'd0, 8'h01, "R5 alarm visible");
    wr(3'd0, 8'h01);
    rd(3'd0, 8'h01, "R5 alarm stays after clear");
    cond_a[0] = 1'b0;
    tick(1);
    wr(3'd0, 8'h01);
    rd(3'd0, 8'h00, "R5 alarm gone then cleared");

    // R6: event coincident with its clear wins
    pulse_a(8'h40);
    wr(3'd0, 8'h40);
    wr_with_event_a(8'h40, 8'h40);
    rd(3'd0, 8'h40, "R6 set wins over clear");
    wr(3'd0, 8'h40);
    rd(3'd0, 8'h00, "R6 later clear works");

    // R12: enable register write and read-back
    wr(3'd3, 8'h11);
    rd(3'd3, 8'h11, "R12 enable A readback");
    chk({7'd0, irq_n}, 8'h01, "R7 no pending after unmask");
    rd(3'd5, 8'h00, "R12 unmapped address");

    // R9 / R10: event interrupt, refresh does not release, clear does
    pulse_a(8'h10);
    chk({7'd0, irq_n}, 8'h00, "R9 event interrupt");
    wr(3'd0, 8'h10);
    chk({7'd0, irq_n}, 8'h00, "R10 refresh keeps interrupt");
    wr(3'd0, 8'h10);
    chk({7'd0, irq_n}, 8'h01, "R10 clear releases interrupt");

    // R8 / R10: alarm interrupts on rise and fall, release while present
    cond_a[0] = 1'b1;
    tick(1);
    chk({7'd0, irq_n}, 8'h00, "R8 alarm rise interrupt");
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h01);
    chk({7'd0, irq_n}, 8'h01, "R10 released while alarm present");
    cond_a[0] = 1'b0;
    tick(1);
    chk({7'd0, irq_n}, 8'h00, "R8 alarm fall interrupt");
    wr(3'd0, 8'h01);
    chk({7'd0, irq_n}, 8'h01, "R10 fall interrupt released");
    rd(3'd0, 8'h00, "R8 alarm bit cleared after fall");

    // R7: disabled bit never interrupts
    pulse_a(8'h80);
    chk({7'd0, irq_n}, 8'h01, "R7 disabled bit7 quiet");
    wr(3'd0, 8'h80);
    wr(3'd0, 8'h80);

    // R11: information register latches but never interrupts
    cond_info = 8'hFF;
    tick(1);
    cond_info = 8'h00;
    tick(1);
    chk({7'd0, irq_n}, 8'h01, "R11 info never interrupts");
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'hFF, "R11 info bits latched");

    // R9 on register B and R10 with two pending sources
    wr(3'd4, 8'h02);
    rd(3'd4, 8'h02, "R12 enable B readback");
    pulse_b(8'h02);
    chk({7'd0, irq_n}, 8'h00, "R9 event interrupt reg B");
    pulse_a(8'h10);
    wr(3'd0, 8'h10);
    wr(3'd0, 8'h10);
    chk({7'd0, irq_n}, 8'h00, "R10 B still pending after A clear");
    wr(3'd1, 8'h02);
    wr(3'd1, 8'h02);
    chk({7'd0, irq_n}, 8'h01, "R10 all sources released");
    rd(3'd1, 8'h00, "R4 reg B cleared");

    tick(3);
    done = 1'b1;
    summary();
  end
endmodule